// File: doc/BRIEF.md
# Tiled Quantizing Image Serializer

This block keeps a square image of 16-bit signed words in internal storage and runs it through two automatic phases. In the compress phase it walks the image one 8 by 8 tile at a time. It feeds every pixel of a tile to an external transform engine and fires that engine once. It then drains the 64 transformed results, scales each one down by 64 with an arithmetic shift, and writes it back to the place its source pixel came from. In the transmit phase the whole image leaves the block as a byte stream under a valid/ready handshake. The words go out in raster order, with each word's upper byte first.

The transform arithmetic is not part of this block. The engine is a peer with simple strobes: a push strobe with data, a go pulse, a done pulse that it returns, and a pop strobe. The pop data is read in the same cycle as the pop strobe. A busy level from the engine holds back every strobe. Before a run, a host fills the image through a raster-addressed load port while the block is idle.

Top module: `tile_quant_ctrl`

## Requirements
- R1: While idle, `ld_en` writes `ld_data` at raster address `ld_addr` = row*64 + column. While a run is in progress, `ld_en` has no effect on the image.
- R2: A `start` pulse while idle begins a run. A `start` during a run is ignored, and that run still finishes with a single `done` pulse.
- R3: Every pushed word is the low 8 bits of the stored pixel, sign-extended to 16 bits.
- R4: Tiles are visited with the tile column stepping fastest inside each tile row, top row first. Inside a tile, the 64 pixels are pushed in row-major order. Exactly one `xf_go` pulse follows each group of 64 pushes, so a run makes 64 go pulses.
- R5: After `xf_go` the block waits for `xf_done`. It then pops 64 results in row-major tile order. Each result is shifted arithmetically right by 6 and stored at the position its source pixel came from.
- R6: `xf_push`, `xf_pop` and `xf_go` are never high while `xf_busy` is high. At most one of these strobes, or `tx_valid`, is high in any cycle.
- R7: After the last tile, the transmit phase starts by itself. It sends 8192 bytes: the words in raster order, each as upper byte then lower byte.
- R8: A byte is consumed only in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, `tx_data` holds steady.
- R9: `done` is high for exactly one cycle, the cycle after the last byte is accepted. At the same time the block returns to idle with `tx_valid` low.
- R10: After reset, `xf_push`, `xf_pop`, `xf_go`, `tx_valid` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Image load strobe, honoured only while idle |
| ld_addr | input | 12 | Raster address of the loaded pixel |
| ld_data | input | 16 | Loaded pixel value |
| start | input | 1 | Begins a run when idle |
| xf_busy | input | 1 | Engine busy; holds back push, pop and go |
| xf_push | output | 1 | Push strobe to the engine |
| xf_push_data | output | 16 | Sign-extended low byte of the pixel being pushed |
| xf_go | output | 1 | One-cycle trigger after a full tile is pushed |
| xf_done | input | 1 | Engine finished the tile; sampled only while waiting |
| xf_pop | output | 1 | Pop strobe to the engine |
| xf_pop_data | input | 16 | Engine result, valid in the cycle of `xf_pop` |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte present |
| tx_ready | input | 1 | Receiver accepts the byte |
| done | output | 1 | One-cycle pulse after the final byte |

## Verification
The properties assume the engine raises `xf_done` only after a go pulse it has accepted. They also assume the engine returns `xf_pop_data` in the same cycle as the pop strobe, and that `xf_busy` is a clean level that never changes between clock edges. The bench stub meets these assumptions. It holds busy high for a fixed delay after each go and then pulses done once. It adds a periodic busy stall that comes from the clock count, and it serves pop data straight from its result buffer. The stub's result depends on the tile count and on the position inside the tile, so any mistake in tile order or pixel order shows up in the transmitted bytes.

// File: rtl/tile_quant_ctrl.sv
module tile_quant_ctrl #(
  parameter int TILE_LG = 3,
  parameter int GRID_LG = 3,
  parameter int DATA_W  = 16,
  parameter int PUSH_W  = 8,
  parameter int QSHIFT  = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ld_en,
  input  logic [2*(TILE_LG+GRID_LG)-1:0]     ld_addr,
  input  logic [DATA_W-1:0]                  ld_data,
  input  logic                               start,
  input  logic                               xf_busy,
  output logic                               xf_push,
  output logic [DATA_W-1:0]                  xf_push_data,
  output logic                               xf_go,
  input  logic                               xf_done,
  output logic                               xf_pop,
  input  logic [DATA_W-1:0]                  xf_pop_data,
  output logic [7:0]                         tx_data,
  output logic                               tx_valid,
  input  logic                               tx_ready,
  output logic                               done
);
  localparam int SIDE_LG = TILE_LG + GRID_LG;
  localparam int ADDR_W  = 2 * SIDE_LG;
  localparam int NPIX    = 1 << ADDR_W;
  localparam int PIX_LG  = 2 * TILE_LG;
  localparam int TIDX_LG = 2 * GRID_LG;
  localparam int BPW     = DATA_W / 8;
  localparam int SUBW    = $clog2(BPW);
  localparam int BCNT_W  = ADDR_W + SUBW;

  typedef enum logic [2:0] {S_IDLE, S_PUSH, S_GO, S_WAIT, S_POP, S_SEND} st_t;

  st_t                st;
  logic [PIX_LG-1:0]  pix;
  logic [TIDX_LG-1:0] tile;
  logic [BCNT_W-1:0]  bcnt;
  logic [DATA_W-1:0]  img [NPIX];

  wire [ADDR_W-1:0] tile_addr = {tile[TIDX_LG-1:GRID_LG], pix[PIX_LG-1:TILE_LG],
                                 tile[GRID_LG-1:0], pix[TILE_LG-1:0]};
  wire [ADDR_W-1:0] tx_addr   = bcnt[BCNT_W-1:SUBW];
  wire [ADDR_W-1:0] rd_addr   = (st == S_SEND) ? tx_addr : tile_addr;
  wire [DATA_W-1:0] rd_word   = img[rd_addr];

  wire [SUBW-1:0]   rev_sel   = SUBW'(BPW - 1) - bcnt[SUBW-1:0];
  wire [DATA_W-1:0] shifted   = rd_word >> {rev_sel, 3'b000};
  wire signed [DATA_W-1:0] qval = $signed(xf_pop_data) >>> QSHIFT;

  assign xf_push_data = {{(DATA_W-PUSH_W){rd_word[PUSH_W-1]}}, rd_word[PUSH_W-1:0]};
  assign xf_push  = (st == S_PUSH) && !xf_busy;
  assign xf_go    = (st == S_GO)   && !xf_busy;
  assign xf_pop   = (st == S_POP)  && !xf_busy;
  assign tx_valid = (st == S_SEND);
  assign tx_data  = shifted[7:0];

  always_ff @(posedge clk) begin
    if (st == S_IDLE && ld_en) img[ld_addr] <= ld_data;
    else if (xf_pop)           img[tile_addr] <= qval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pix  <= '0;
      tile <= '0;
      bcnt <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          st   <= S_PUSH;
          pix  <= '0;
          tile <= '0;
          bcnt <= '0;
        end
        S_PUSH: if (xf_push) begin
          pix <= pix + 1'b1;
          if (&pix) st <= S_GO;
        end
        S_GO:   if (xf_go)   st <= S_WAIT;
        S_WAIT: if (xf_done) st <= S_POP;
        S_POP:  if (xf_pop) begin
          pix <= pix + 1'b1;
          if (&pix) begin
            tile <= tile + 1'b1;
            st   <= (&tile) ? S_SEND : S_PUSH;
          end
        end
        S_SEND: if (tx_ready) begin
          bcnt <= bcnt + 1'b1;
          if (&bcnt) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module tile_quant_ctrl_chk #(
  parameter int TILE_LG = 3
) (
  input logic clk,
  input logic rst_n,
  input logic xf_busy,
  input logic xf_push,
  input logic [15:0] xf_push_data,
  input logic xf_go,
  input logic xf_pop,
  input logic [7:0] tx_data,
  input logic tx_valid,
  input logic tx_ready,
  input logic done
);
  localparam int TPIX = 1 << (2 * TILE_LG);
  localparam int CW   = 2 * TILE_LG + 1;

  logic [CW-1:0] n_push, n_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_push <= '0;
      n_pop  <= '0;
    end else begin
      if (xf_go) begin
        n_push <= '0;
        n_pop  <= '0;
      end else begin
        if (xf_push) n_push <= n_push + 1'b1;
        if (xf_pop)  n_pop  <= n_pop + 1'b1;
      end
    end
  end

  p_push_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xf_push |-> (xf_push_data[15:8] == {8{xf_push_data[7]}}));

  p_go_after_tile_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xf_go |-> (n_push == CW'(TPIX)));

  p_pop_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xf_pop |-> (n_pop < CW'(TPIX)));

  p_busy_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xf_busy |-> !(xf_push || xf_pop || xf_go));

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xf_push, xf_pop, xf_go, tx_valid}));

  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_done_after_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(tx_valid && tx_ready) && !tx_valid));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind tile_quant_ctrl tile_quant_ctrl_chk #(.TILE_LG(TILE_LG)) u_chk (
  .clk(clk), .rst_n(rst_n), .xf_busy(xf_busy), .xf_push(xf_push),
  .xf_push_data(xf_push_data), .xf_go(xf_go), .xf_pop(xf_pop),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .done(done)
);

// File: tb/tile_quant_ctrl_test.sv
`timescale 1ns/1ps
module tile_quant_ctrl_test;
  logic clk = 0;
  logic rst_n = 0;
  logic ld_en = 0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic start = 0;
  logic xf_busy;
  logic xf_push, xf_go, xf_pop, xf_done;
  logic [15:0] xf_push_data, xf_pop_data;
  logic [7:0] tx_data;
  logic tx_valid, done;
  logic tx_ready = 0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tile_quant_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .start(start), .xf_busy(xf_busy), .xf_push(xf_push), .xf_push_data(xf_push_data),
    .xf_go(xf_go), .xf_done(xf_done), .xf_pop(xf_pop), .xf_pop_data(xf_pop_data),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .done(done)
  );

  // transform stub: result depends on value, in-tile position and tile count
  logic stub_clr = 0;
  logic stall_en = 0;
  logic signed [15:0] ibuf [64];
  logic signed [15:0] obuf [64];
  logic [15:0] plog [64];
  logic [5:0] pi, po, tcnt;
  logic [6:0] ngo, npl;
  logic [2:0] dly;
  logic xbusy, xdone;

  assign xf_busy     = xbusy | (stall_en & (cyc % 7 == 3));
  assign xf_done     = xdone;
  assign xf_pop_data = obuf[po];

  always @(posedge clk) begin
    xdone <= 1'b0;
    if (!rst_n || stub_clr) begin
      pi <= '0; po <= '0; tcnt <= '0; ngo <= '0; npl <= '0; xbusy <= 1'b0; dly <= '0;
    end else begin
      if (xf_push) begin
        ibuf[pi] <= xf_push_data;
        pi <= pi + 1'b1;
        if (npl < 64) begin
          plog[npl[5:0]] <= xf_push_data;
          npl <= npl + 1'b1;
        end
      end
      if (xf_go) begin
        xbusy <= 1'b1;
        dly <= 3'd5;
        ngo <= ngo + 1'b1;
      end else if (xbusy) begin
        if (dly == 0) begin
          xbusy <= 1'b0;
          xdone <= 1'b1;
          for (int j = 0; j < 64; j++)
            obuf[j] <= 16'(int'(ibuf[j]) * 100 + j * 7 + int'(tcnt) * 11);
          tcnt <= tcnt + 1'b1;
        end else dly <= dly - 1'b1;
      end
      if (xf_pop) po <= po + 1'b1;
    end
  end

  logic [15:0] img [4096];

  function automatic int sx8(logic [15:0] w);
    logic signed [7:0] b;
    b = w[7:0];
    return int'(b);
  endfunction

  function automatic logic [15:0] exp_word(int r, int c);
    int t, j, v;
    logic signed [15:0] v16;
    t = (r / 8) * 8 + (c / 8);
    j = (r % 8) * 8 + (c % 8);
    v = sx8(img[r * 64 + c]) * 100 + j * 7 + t * 11;
    v16 = v[15:0];
    return v16 >>> 6;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic load_image(int pat);
    for (int i = 0; i < 4096; i++) begin
      if (pat == 0) img[i] = 16'((i * 29 + 5) ^ (i << 7));
      else          img[i] = 16'((i * 173 + 91) ^ ((i >> 4) * 3) ^ 16'hA5C3);
      @(negedge clk);
      ld_en = 1; ld_addr = 12'(i); ld_data = img[i];
    end
    @(negedge clk);
    ld_en = 0;
  endtask

  // one full run: compress then receive all bytes, checking every byte
  task automatic run(int pat, bit bp, bit stall, bit disturb, string tag);
    int n = 0;
    int bad = 0;
    int dones = 0;
    logic [15:0] w;
    logic [7:0] eb;
    load_image(pat);
    stall_en = stall;
    @(negedge clk); stub_clr = 1;
    @(negedge clk); stub_clr = 0; start = 1;
    @(negedge clk); start = 0;
    if (disturb) begin
      repeat (10) @(negedge clk);
      ld_en = 1; ld_addr = 12'd4095; ld_data = 16'h7E7E; start = 1;   // R1, R2: ignored mid-run
      @(negedge clk);
      ld_en = 0; start = 0;
    end
    while (n < 8192) begin
      @(negedge clk);
      if (done) dones++;
      tx_ready = bp ? (cyc % 3 != 1) : 1'b1;
      if (tx_valid && tx_ready) begin
        w  = exp_word((n / 2) / 64, (n / 2) % 64);
        eb = (n % 2 == 0) ? w[15:8] : w[7:0];
        if (tx_data !== eb) begin
          bad++;
          check(0, "R5/R7", $sformatf("%s byte %0d", tag, n), tx_data, eb);
        end
        n++;
      end
    end
    check(bad == 0, "R7", {tag, " all bytes match"}, bad, 0);
    @(negedge clk);
    tx_ready = 0;
    check(done === 1'b1, "R9", {tag, " done after last byte"}, done, 1);
    check(tx_valid === 1'b0, "R9", {tag, " idle after last byte"}, tx_valid, 0);
    check(dones == 0, "R2", {tag, " no early done"}, dones, 0);
    @(negedge clk);
    check(done === 1'b0, "R9", {tag, " done lasts one cycle"}, done, 0);
    check(ngo == 64, "R4", {tag, " go pulses per run"}, ngo, 64);
    stall_en = 0;
  endtask

  task automatic t_reset;
    check(xf_push === 0 && xf_pop === 0 && xf_go === 0, "R10", "strobes low after reset",
          {xf_push, xf_pop, xf_go}, 0);
    check(tx_valid === 0 && done === 0, "R10", "tx idle after reset", {tx_valid, done}, 0);
  endtask

  task automatic t_plain;
    run(0, 0, 0, 0, "plain");
    for (int j = 0; j < 64; j++)
      check(plog[j] == 16'(sx8(img[(j / 8) * 64 + (j % 8)])), "R3",
            $sformatf("push %0d of first tile", j), plog[j],
            16'(sx8(img[(j / 8) * 64 + (j % 8)])));
  endtask

  task automatic t_backpressure;
    run(1, 1, 1, 0, "bp_stall");
  endtask

  task automatic t_ignore;
    run(0, 1, 0, 1, "ignore");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_backpressure();
    t_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 180000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule